// File: doc/BRIEF.md
# USB Transaction Status Queue

This block sits between a USB serial interface engine and the processor that services it. Each time the engine finishes with a buffer descriptor, it pulses a push strobe together with the endpoint number, the transfer direction and the odd/even buffer selector of that transaction. The block packs these into a one-byte status entry and queues it. The processor can then work on one completed transaction while the engine goes on to the next.

The processor sees the oldest queued entry through a read-only status window. A token-done flag signals that the window holds valid data. Writing one to the flag's clear input consumes the entry. If more entries are waiting, the flag stays raised and the window moves to the next entry in the following cycle. A push that arrives while the queue is full is dropped and recorded in a sticky overflow flag, which software clears separately.

Top module: `usb_xfer_status_queue`

## Requirements
- R1: After reset the queue is empty, `done_o` is 0, `status_o` reads 0x00 and `ovf_o` is 0.
- R2: Entry layout in `status_o`: endpoint number in bits 7:4, direction flag in bit 3, odd/even flag in bit 2, and bits 1:0 always 0.
- R3: A push into an empty queue makes `done_o` 1 after the next rising clock edge, and `status_o` then shows that entry.
- R4: Entries leave the queue in arrival order. A push while the flag is pending never changes the entry currently shown.
- R5: While `done_o` is 0, `status_o` reads 0x00.
- R6: A `done_clr_i` pulse while `done_o` is 1 removes the head entry. If another entry is waiting, `done_o` stays 1 and the window shows that entry after the edge. Otherwise `done_o` falls to 0.
- R7: A `done_clr_i` pulse while `done_o` is 0 has no effect on the queue or the outputs.
- R8: A push while four entries are held and no pop occurs is discarded and sets `ovf_o` on the next edge. The held entries are unchanged.
- R9: `ovf_o` stays set until `ovf_clr_i` is pulsed. If an overflow and a clear coincide, the overflow wins.
- R10: A push and a valid pop in the same cycle are both honoured and the entry count is unchanged. This also holds when the queue is full.
- R11: The queue holds at most four entries. Four pushes into an empty queue are all later read back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Engine has finished with a buffer descriptor; enqueue a status entry |
| push_ep_i | input | 4 | Endpoint number of the finished transaction |
| push_dir_i | input | 1 | Direction of the finished transaction (1 = transmit) |
| push_odd_i | input | 1 | Odd/even buffer selector used by the transaction |
| done_clr_i | input | 1 | Write-one-to-clear of the token-done flag; pops the head entry |
| ovf_clr_i | input | 1 | Write-one-to-clear of the overflow flag |
| status_o | output | 8 | Status window: head entry while `done_o` is 1, else 0x00 |
| done_o | output | 1 | Token-done flag: the window holds a valid entry |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The assertions assume single-cycle, synchronous control pulses. They also assume the clear input is meant as a pop request only when the flag is raised; a clear against an empty queue is treated as a legal no-op and not as an error. The stimulus drives every input half a cycle away from the active edge. It walks the occupancy through empty, partial and full, using three push/clear density phases plus directed sequences for coincident push and pop at the full boundary. Every output is compared on every cycle against an arithmetic queue model.

// File: rtl/usb_stq_pkg.sv
package usb_stq_pkg;

    localparam int EP_W    = 4;
    localparam int RSVD_W  = 2;
    localparam int ENTRY_W = EP_W + 2 + RSVD_W;

    typedef struct packed {
        logic [EP_W-1:0]   ep;
        logic              dir;
        logic              odd;
        logic [RSVD_W-1:0] rsvd;
    } stq_entry_t;

endpackage

// File: rtl/stq_store.sv
module stq_store
    import usb_stq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [PTR_W-1:0] wr_ptr_i,
    input  stq_entry_t       wr_data_i,
    input  logic [PTR_W-1:0] rd_ptr_i,
    output stq_entry_t       rd_data_o
);

    stq_entry_t slot_d [DEPTH];
    stq_entry_t slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_comb begin
            slot_d[g] = slot_q[g];
            if (wr_en_i && (wr_ptr_i == PTR_W'(g))) begin
                slot_d[g] = wr_data_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else begin
                slot_q[g] <= slot_d[g];
            end
        end
    end

    assign rd_data_o = slot_q[rd_ptr_i];

endmodule

// File: rtl/stq_ctrl.sv
module stq_ctrl #(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             clr_i,
    input  logic             ovf_clr_i,
    output logic             wr_en_o,
    output logic [PTR_W-1:0] wr_ptr_o,
    output logic [PTR_W-1:0] rd_ptr_o,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o
);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] count;
        logic             ovf;
    } ctrl_state_t;

    ctrl_state_t st_d;
    ctrl_state_t st_q;

    logic pop;
    logic full;
    logic accept;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d   = st_q;
        pop    = clr_i && (st_q.count != '0);
        full   = (st_q.count == CNT_W'(DEPTH));
        accept = push_i && (!full || pop);

        if (accept) begin
            st_d.wr_ptr = bump(st_q.wr_ptr);
        end
        if (pop) begin
            st_d.rd_ptr = bump(st_q.rd_ptr);
        end
        case ({accept, pop})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase

        if (push_i && !accept) begin
            st_d.ovf = 1'b1;
        end else if (ovf_clr_i) begin
            st_d.ovf = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en_o  = accept;
    assign wr_ptr_o = st_q.wr_ptr;
    assign rd_ptr_o = st_q.rd_ptr;
    assign count_o  = st_q.count;
    assign ovf_o    = st_q.ovf;

endmodule

// File: rtl/usb_xfer_status_queue.sv
module usb_xfer_status_queue
    import usb_stq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_i,
    input  logic [EP_W-1:0]    push_ep_i,
    input  logic               push_dir_i,
    input  logic               push_odd_i,
    input  logic               done_clr_i,
    input  logic               ovf_clr_i,
    output logic [ENTRY_W-1:0] status_o,
    output logic               done_o,
    output logic               ovf_o
);

    logic             wr_en;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] occ;
    stq_entry_t       new_entry;
    stq_entry_t       head;

    always_comb begin
        new_entry      = '0;
        new_entry.ep   = push_ep_i;
        new_entry.dir  = push_dir_i;
        new_entry.odd  = push_odd_i;
        new_entry.rsvd = '0;
    end

    stq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (push_i),
        .clr_i     (done_clr_i),
        .ovf_clr_i (ovf_clr_i),
        .wr_en_o   (wr_en),
        .wr_ptr_o  (wr_ptr),
        .rd_ptr_o  (rd_ptr),
        .count_o   (occ),
        .ovf_o     (ovf_o)
    );

    stq_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_ptr_i  (wr_ptr),
        .wr_data_i (new_entry),
        .rd_ptr_i  (rd_ptr),
        .rd_data_o (head)
    );

    assign done_o   = (occ != '0);
    assign status_o = done_o ? ENTRY_W'(head) : '0;

endmodule

// File: rtl/stq_checker.sv
module stq_checker #(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_i,
    input logic [3:0]       push_ep_i,
    input logic             push_dir_i,
    input logic             push_odd_i,
    input logic             done_clr_i,
    input logic             ovf_clr_i,
    input logic [7:0]       status_o,
    input logic             done_o,
    input logic             ovf_o,
    input logic [CNT_W-1:0] occ
);

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[1:0] == 2'b00);

    assert_first_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && occ == '0) |=> done_o &&
        status_o == {$past(push_ep_i), $past(push_dir_i), $past(push_odd_i), 2'b00});

    assert_head_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !done_clr_i) |=> $stable(status_o));

    assert_idle_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> status_o == 8'h00);

    assert_rearm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_clr_i && occ > CNT_W'(1)) |=> done_o);

    assert_last_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_clr_i && occ == CNT_W'(1) && !push_i) |=> !done_o);

    assert_idle_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_clr_i && !done_o && !push_i) |=> !done_o);

    assert_drop_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !done_clr_i && occ == CNT_W'(DEPTH)) |=> ovf_o && occ == CNT_W'(DEPTH));

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !ovf_clr_i) |=> ovf_o);

    assert_push_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && done_clr_i && occ != '0) |=> occ == $past(occ));

    assert_capacity_R11: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH));

endmodule

bind usb_xfer_status_queue stq_checker #(.DEPTH(DEPTH)) u_stq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (push_i),
    .push_ep_i  (push_ep_i),
    .push_dir_i (push_dir_i),
    .push_odd_i (push_odd_i),
    .done_clr_i (done_clr_i),
    .ovf_clr_i  (ovf_clr_i),
    .status_o   (status_o),
    .done_o     (done_o),
    .ovf_o      (ovf_o),
    .occ        (occ)
);

// File: tb/test_usb_xfer_status_queue.sv
`timescale 1ns/1ps
module test_usb_xfer_status_queue;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_i = 1'b0;
    logic [3:0] push_ep_i = '0;
    logic       push_dir_i = 1'b0;
    logic       push_odd_i = 1'b0;
    logic       done_clr_i = 1'b0;
    logic       ovf_clr_i = 1'b0;
    logic [7:0] status_o;
    logic       done_o;
    logic       ovf_o;

    int checks = 0;
    int failures = 0;

    logic [7:0] mq [4];
    int         mcnt = 0;
    bit         movf = 1'b0;

    always #2.5 clk = ~clk;

    usb_xfer_status_queue i_usb_xfer_status_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (push_i),
        .push_ep_i  (push_ep_i),
        .push_dir_i (push_dir_i),
        .push_odd_i (push_odd_i),
        .done_clr_i (done_clr_i),
        .ovf_clr_i  (ovf_clr_i),
        .status_o   (status_o),
        .done_o     (done_o),
        .ovf_o      (ovf_o)
    );

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic compare_all(input string tag);
        logic [7:0] exp_stat;
        exp_stat = (mcnt > 0) ? mq[0] : 8'h00;
        check({tag, " done"},   int'(done_o),   int'(mcnt > 0));
        check({tag, " status"}, int'(status_o), int'(exp_stat));
        check({tag, " ovf"},    int'(ovf_o),    int'(movf));
    endtask

    task automatic step(input bit p, input logic [3:0] ep, input bit d, input bit o,
                        input bit c, input bit oc, input string tag);
        bit pop;
        bit acc;
        @(negedge clk);
        push_i = p; push_ep_i = ep; push_dir_i = d; push_odd_i = o;
        done_clr_i = c; ovf_clr_i = oc;
        @(posedge clk);
        pop = c && (mcnt > 0);
        acc = p && ((mcnt < 4) || pop);
        if (pop) begin
            for (int k = 0; k < 3; k++) mq[k] = mq[k+1];
            mcnt--;
        end
        if (acc) begin
            mq[mcnt] = {ep, d, o, 2'b00};
            mcnt++;
        end
        if (p && !acc) movf = 1'b1;
        else if (oc) movf = 1'b0;
        #1;
        compare_all(tag);
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(negedge clk);
        #1;
        compare_all("R1 reset");
        rst_n = 1'b1;
        step(0, 4'h0, 0, 0, 0, 0, "R1 idle after reset");

        // R2 layout and R3 first push
        step(1, 4'h5, 1, 0, 0, 0, "R2 R3 first push");
        check("R2 exact byte", int'(status_o), 8'h58);
        step(1, 4'hA, 0, 1, 0, 0, "R4 second push keeps head");
        step(1, 4'hF, 1, 1, 0, 0, "R4 third push keeps head");
        step(0, 4'h0, 0, 0, 1, 0, "R6 pop rearms");
        check("R2 second entry", int'(status_o), 8'hA4);
        step(0, 4'h0, 0, 0, 1, 0, "R6 pop rearms again");
        check("R2 third entry", int'(status_o), 8'hFC);
        step(0, 4'h0, 0, 0, 1, 0, "R6 last pop drops flag");
        step(0, 4'h0, 0, 0, 0, 0, "R5 window zero when idle");
        step(0, 4'h0, 0, 0, 1, 0, "R7 clear while idle");
        step(0, 4'h0, 0, 0, 0, 0, "R7 still empty");

        // R11 capacity and R8 overflow
        for (int i = 0; i < 4; i++) step(1, 4'(i + 1), i[0], i[1], 0, 0, "R11 fill");
        step(1, 4'h9, 1, 1, 0, 0, "R8 push while full dropped");
        step(1, 4'h7, 0, 0, 0, 1, "R9 overflow beats clear");
        step(0, 4'h0, 0, 0, 0, 0, "R9 sticky");
        step(1, 4'hE, 1, 0, 1, 0, "R10 push and pop at full");
        step(1, 4'hD, 0, 1, 1, 0, "R10 push and pop at full again");
        step(0, 4'h0, 0, 0, 0, 1, "R9 clear overflow");
        for (int i = 0; i < 5; i++) step(0, 4'h0, 0, 0, 1, 0, "R4 R11 drain order");

        // sweeps in three density phases
        lf = 16'hACE1;
        for (int ph = 0; ph < 3; ph++) begin
            for (int n = 0; n < 1500; n++) begin
                bit p;
                bit c;
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                p = (ph == 0) ? (lf[1:0] != 2'b00) : (ph == 1) ? lf[0] : (lf[1:0] == 2'b00);
                c = (ph == 0) ? (lf[3:2] == 2'b00) : (ph == 1) ? lf[2] : (lf[3:2] != 2'b00);
                step(p, lf[7:4], lf[8], lf[9], c, (lf[14:11] == 4'h0),
                     "R4 R6 R8 R9 R10 sweep");
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule